// File: doc/BRIEF.md
# AC-Link Bring-Up Reset Sequencer

This block brings an audio codec link out of reset when the chip starts. On an accepted start request it looks at the codec-ready input and picks one of two paths. A codec that is not yet ready gets a cold reset, which pulses the active-low codec reset line while the link is enabled. A codec that already reports ready gets a warm reset, which pulses the sync line while the reset line stays released. Each phase has its own length.

After either path the sequencer drives the link pins to their run value, with the power-up control asserted. It then checks codec-ready at fixed intervals up to a bounded number of times. The result is either a one-cycle done pulse or a sticky timeout error. Every delay is counted in microsecond ticks from a `us_tick` enable, so the block does not depend on the clock frequency. Start requests that arrive while a sequence is running are dropped.

Top module: `acl_reset_seq`

## Requirements
- R1: After reset, every link pin (`link_en`, `codec_rst_n`, `link_sync`, `link_pwr`) and `busy`, `done`, `timeout_err` are 0.
- R2: A start accepted while `codec_rdy` is 0 gives a cold reset. The pins {en,rst_n,sync,pwr} are 4'b1000 for exactly RST_LOW_US ticks, then 4'b1100 for exactly RST_REC_US ticks.
- R3: A start accepted while `codec_rdy` is 1 gives a warm reset. The pins are 4'b1100 for SYNC_LOW_US ticks, then 4'b1110 for SYNC_HIGH_US ticks, then 4'b1100 for SYNC_TAIL_US ticks. Sync is never high while reset is low.
- R4: After either reset path the pins take the run value 4'b1101. They keep that value after the sequence ends, until the next accepted start.
- R5: `codec_rdy` is sampled in the first cycle of the run phase and then once after every POLL_GAP_US ticks. A ready level that is present only between samples has no effect.
- R6: A successful sample ends the sequence: `done` is high for exactly one cycle and `busy` falls on the same edge.
- R7: If POLL_TRIES samples all fail, `timeout_err` rises and `busy` falls on the edge of the last sample, and `done` stays 0. The last sample comes (POLL_TRIES-1)*POLL_GAP_US ticks into the run phase.
- R8: `timeout_err` stays set until the next accepted start, and it clears on that edge.
- R9: A `start` pulse while `busy` is high is ignored. Phase lengths and the outcome stay the same.
- R10: Phase lengths are counted in `us_tick` pulses only, whatever the spacing of those pulses in clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle enable, once per microsecond |
| start | input | 1 | Request to begin a sequence; taken only when idle |
| codec_rdy | input | 1 | Primary codec ready status |
| link_en | output | 1 | Link enable |
| codec_rst_n | output | 1 | Active-low codec reset |
| link_sync | output | 1 | Sync line drive |
| link_pwr | output | 1 | Power-up run control |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on success |
| timeout_err | output | 1 | Sticky failure flag |

## Verification
A wrong phase state or a counter that is off by one shows at the pins within one phase. The pin pattern stays too long or too short by a whole number of ticks, or the path differs from what the ready level at start calls for. A fault in the poll logic shows up later, in the run phase, as done or timeout arriving at a tick count that is not a multiple of the poll interval, or as a ready pulse between samples ending the sequence. The bench sweeps the tick spacing and the point where ready rises across every sample slot and both sides of the last one, so each of these faults leads to a wrong tick count or a wrong outcome.

// File: rtl/acl_seq_pkg.sv
package acl_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_COLD_LOW  = 3'd1,
        ST_COLD_REC  = 3'd2,
        ST_WARM_LOW  = 3'd3,
        ST_WARM_HIGH = 3'd4,
        ST_WARM_TAIL = 3'd5,
        ST_POLL      = 3'd6
    } seq_state_e;

    // Link pin group: enable, active-low reset, sync, power-up control
    typedef struct packed {
        logic en;
        logic rst_n;
        logic sync;
        logic pwr;
    } link_pins_t;

    typedef struct packed {
        seq_state_e st;
        logic       pend;   // a ready sample is due this cycle
        logic       done;
        logic       err;
    } seq_ctl_t;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic link_pins_t pins_for(seq_state_e s, link_pins_t hold);
        link_pins_t p;
        case (s)
            ST_COLD_LOW:  p = '{en: 1'b1, rst_n: 1'b0, sync: 1'b0, pwr: 1'b0};
            ST_COLD_REC,
            ST_WARM_LOW,
            ST_WARM_TAIL: p = '{en: 1'b1, rst_n: 1'b1, sync: 1'b0, pwr: 1'b0};
            ST_WARM_HIGH: p = '{en: 1'b1, rst_n: 1'b1, sync: 1'b1, pwr: 1'b0};
            ST_POLL:      p = '{en: 1'b1, rst_n: 1'b1, sync: 1'b0, pwr: 1'b1};
            default:      p = hold;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/acl_tick_timer.sv
module acl_tick_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         hit
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        hit   = inc && !clr && (cnt_q == limit - 1'b1);
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (hit) cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R10: a counting step never starts from at or past the terminal value
    a_r10_cnt_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> (cnt_q < limit));

endmodule

// File: rtl/acl_pin_drive.sv
module acl_pin_drive
    import acl_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e nxt_st,
    output logic       link_en,
    output logic       codec_rst_n,
    output logic       link_sync,
    output logic       link_pwr
);

    link_pins_t pins_d, pins_q;

    always_comb begin
        pins_d = pins_for(nxt_st, pins_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pins_q <= '0;
        else        pins_q <= pins_d;
    end

    assign link_en     = pins_q.en;
    assign codec_rst_n = pins_q.rst_n;
    assign link_sync   = pins_q.sync;
    assign link_pwr    = pins_q.pwr;

    // R3: sync is never driven while the codec is held in reset
    a_r3_no_sync_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !codec_rst_n |-> !link_sync);

    // R4: the power-up value comes with enable, released reset and sync low
    a_r4_run_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        link_pwr |-> (link_en && codec_rst_n && !link_sync));

endmodule

// File: rtl/acl_reset_seq.sv
module acl_reset_seq
    import acl_seq_pkg::*;
#(
    parameter int unsigned RST_LOW_US   = 100,
    parameter int unsigned RST_REC_US   = 5,
    parameter int unsigned SYNC_LOW_US  = 100,
    parameter int unsigned SYNC_HIGH_US = 5,
    parameter int unsigned SYNC_TAIL_US = 5,
    parameter int unsigned POLL_GAP_US  = 5000,
    parameter int unsigned POLL_TRIES   = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic start,
    input  logic codec_rdy,
    output logic link_en,
    output logic codec_rst_n,
    output logic link_sync,
    output logic link_pwr,
    output logic busy,
    output logic done,
    output logic timeout_err
);

    localparam int unsigned TMAX = max2(max2(max2(RST_LOW_US, RST_REC_US),
                                             max2(SYNC_LOW_US, SYNC_HIGH_US)),
                                        max2(SYNC_TAIL_US, POLL_GAP_US));
    localparam int unsigned TW   = $clog2(TMAX + 1);
    localparam int unsigned AW   = $clog2(POLL_TRIES + 1);

    seq_ctl_t        ctl_d, ctl_q;
    logic [TW-1:0]   tmr_lim;
    logic            tmr_clr, tmr_hit;
    logic            sample, try_inc, try_hit;

    always_comb begin
        case (ctl_q.st)
            ST_COLD_LOW:  tmr_lim = TW'(RST_LOW_US);
            ST_COLD_REC:  tmr_lim = TW'(RST_REC_US);
            ST_WARM_LOW:  tmr_lim = TW'(SYNC_LOW_US);
            ST_WARM_HIGH: tmr_lim = TW'(SYNC_HIGH_US);
            ST_WARM_TAIL: tmr_lim = TW'(SYNC_TAIL_US);
            ST_POLL:      tmr_lim = TW'(POLL_GAP_US);
            default:      tmr_lim = TW'(1);
        endcase
        tmr_clr = (ctl_q.st == ST_IDLE);
        sample  = (ctl_q.st == ST_POLL) && ctl_q.pend;
        try_inc = sample && !codec_rdy;
    end

    acl_tick_timer #(.W(TW)) i_phase_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .inc   (us_tick),
        .limit (tmr_lim),
        .hit   (tmr_hit)
    );

    acl_tick_timer #(.W(AW)) i_try_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .inc   (try_inc),
        .limit (AW'(POLL_TRIES)),
        .hit   (try_hit)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.err = 1'b0;
                    ctl_d.st  = codec_rdy ? ST_WARM_LOW : ST_COLD_LOW;
                end
            end
            ST_COLD_LOW:  if (tmr_hit) ctl_d.st = ST_COLD_REC;
            ST_COLD_REC: begin
                if (tmr_hit) begin
                    ctl_d.st   = ST_POLL;
                    ctl_d.pend = 1'b1;
                end
            end
            ST_WARM_LOW:  if (tmr_hit) ctl_d.st = ST_WARM_HIGH;
            ST_WARM_HIGH: if (tmr_hit) ctl_d.st = ST_WARM_TAIL;
            ST_WARM_TAIL: begin
                if (tmr_hit) begin
                    ctl_d.st   = ST_POLL;
                    ctl_d.pend = 1'b1;
                end
            end
            ST_POLL: begin
                if (tmr_hit) ctl_d.pend = 1'b1;
                if (sample) begin
                    if (codec_rdy) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                        ctl_d.pend = 1'b0;
                    end else if (try_hit) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.err  = 1'b1;
                        ctl_d.pend = 1'b0;
                    end else if (!tmr_hit) begin
                        ctl_d.pend = 1'b0;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, pend: 1'b0, done: 1'b0, err: 1'b0};
        else        ctl_q <= ctl_d;
    end

    acl_pin_drive i_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .nxt_st      (ctl_d.st),
        .link_en     (link_en),
        .codec_rst_n (codec_rst_n),
        .link_sync   (link_sync),
        .link_pwr    (link_pwr)
    );

    assign busy        = (ctl_q.st != ST_IDLE);
    assign done        = ctl_q.done;
    assign timeout_err = ctl_q.err;

    // R6: success is a single-cycle pulse
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: success leaves the block idle with the run pins applied
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && link_pwr));

    // R7: a timeout never comes with a success pulse
    a_r7_err_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (!done && !busy));

    // R5: a sequence only ends through a ready sample or the try limit
    a_r5_exit_by_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || $rose(timeout_err)));

    // R8: the error flag holds until a start is taken
    a_r8_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_err && !start) |=> timeout_err);

    // R8: a start taken with the flag set clears it and begins a sequence
    a_r8_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_err && start) |=> (!timeout_err && busy));

    // R9: a start during a sequence does not send the pins back to the first phase
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && link_pwr) |=> (link_pwr || !busy));

endmodule

// File: tb/test_acl_reset_seq.sv
module test_acl_reset_seq;

    localparam int CLK_PERIOD = 10;
    localparam int P_RLOW  = 6;
    localparam int P_RREC  = 3;
    localparam int P_SLOW  = 5;
    localparam int P_SHIGH = 2;
    localparam int P_STAIL = 3;
    localparam int P_GAP   = 4;
    localparam int P_TRIES = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b0;
    logic start = 1'b0;
    logic codec_rdy = 1'b0;
    logic link_en, codec_rst_n, link_sync, link_pwr, busy, done, timeout_err;

    int checks = 0;
    int fails = 0;

    acl_reset_seq #(
        .RST_LOW_US   (P_RLOW),
        .RST_REC_US   (P_RREC),
        .SYNC_LOW_US  (P_SLOW),
        .SYNC_HIGH_US (P_SHIGH),
        .SYNC_TAIL_US (P_STAIL),
        .POLL_GAP_US  (P_GAP),
        .POLL_TRIES   (P_TRIES)
    ) i_acl_reset_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .us_tick     (us_tick),
        .start       (start),
        .codec_rdy   (codec_rdy),
        .link_en     (link_en),
        .codec_rst_n (codec_rst_n),
        .link_sync   (link_sync),
        .link_pwr    (link_pwr),
        .busy        (busy),
        .done        (done),
        .timeout_err (timeout_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // tick generator: spacing set by tick_div (>= 2)
    int tick_div = 2;
    int tick_ph = 0;
    initial begin
        forever begin
            @(posedge clk);
            #1;
            tick_ph = tick_ph + 1;
            us_tick = ((tick_ph % tick_div) == 0);
        end
    end

    // pin monitor
    logic [3:0] pins;
    assign pins = {link_en, codec_rst_n, link_sync, link_pwr};

    logic       mon_clr = 1'b0;
    logic [3:0] prev_pins = 4'b0;
    int         seg = -1;
    logic [3:0] seg_pins [0:7];
    int         seg_ticks [0:7];
    int         pl = 0;          // run-phase ticks, live
    int         pd = 0;          // run-phase ticks, only those followed by a busy cycle
    logic       pend_tick = 1'b0;
    int         done_cnt = 0;

    always @(negedge clk) begin
        if (mon_clr) begin
            seg = -1;
            for (int i = 0; i < 8; i++) begin
                seg_pins[i] = 4'b0;
                seg_ticks[i] = 0;
            end
            pl = 0;
            pd = 0;
            pend_tick = 1'b0;
            done_cnt = 0;
            prev_pins = pins;
        end else begin
            if (pins != prev_pins && seg < 7) begin
                seg = seg + 1;
                seg_pins[seg] = pins;
            end
            prev_pins = pins;
            if (us_tick && seg >= 0) seg_ticks[seg] = seg_ticks[seg] + 1;
            if (pend_tick && busy) pd = pd + 1;
            pend_tick = us_tick && busy && (pins == 4'b1101);
            if (pend_tick) pl = pl + 1;
            if (done) done_cnt = done_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_sample(input int raise_at, input int pulse_at);
        int best;
        best = 1 << 20;
        if (raise_at == 0) best = 0;
        else if (raise_at > 0) best = (raise_at + P_GAP - 1) / P_GAP;
        if (pulse_at > 0 && (pulse_at % P_GAP) == 0 && (pulse_at / P_GAP) < best)
            best = pulse_at / P_GAP;
        return best;
    endfunction

    task automatic run_case(input bit warm, input int raise_at, input int pulse_at,
                            input int inject_at);
        int  cyc;
        int  j;
        bit  pulsed;
        bit  pulse_on;
        bit  ok_exp;
        int  final_seg;
        @(posedge clk);
        #1;
        mon_clr = 1'b1;
        codec_rdy = warm;
        @(posedge clk);
        #1;
        mon_clr = 1'b0;
        start = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
        codec_rdy = (raise_at == 0) ? 1'b1 : 1'b0;
        #1;
        // R8: an accepted start clears the error flag and begins a sequence
        chk(busy && !timeout_err, "R8 start clears error", {30'b0, busy, timeout_err}, 2);
        cyc = 0;
        pulsed = 1'b0;
        pulse_on = 1'b0;
        forever begin
            @(posedge clk);
            #2;
            cyc = cyc + 1;
            start = (inject_at == cyc);
            if (pulse_on) begin
                codec_rdy = 1'b0;
                pulse_on = 1'b0;
            end
            if (raise_at > 0 && pl >= raise_at) codec_rdy = 1'b1;
            if (pulse_at > 0 && !pulsed && pl >= pulse_at) begin
                codec_rdy = 1'b1;
                pulsed = 1'b1;
                pulse_on = 1'b1;
            end
            if (!busy || cyc > 5000) break;
        end
        start = 1'b0;
        @(posedge clk);
        #2;
        codec_rdy = 1'b0;

        if (warm) begin
            chk(seg_pins[0] == 4'b1100, "R3 warm phase1 pins", int'(seg_pins[0]), 12);
            chk(seg_ticks[0] == P_SLOW, "R3 R10 warm sync-low ticks", seg_ticks[0], P_SLOW);
            chk(seg_pins[1] == 4'b1110, "R3 warm phase2 pins", int'(seg_pins[1]), 14);
            chk(seg_ticks[1] == P_SHIGH, "R3 R10 warm sync-high ticks", seg_ticks[1], P_SHIGH);
            chk(seg_pins[2] == 4'b1100, "R3 warm phase3 pins", int'(seg_pins[2]), 12);
            chk(seg_ticks[2] == P_STAIL, "R3 R10 warm tail ticks", seg_ticks[2], P_STAIL);
            final_seg = 3;
        end else begin
            chk(seg_pins[0] == 4'b1000, "R2 cold phase1 pins", int'(seg_pins[0]), 8);
            chk(seg_ticks[0] == P_RLOW, "R2 R10 cold reset-low ticks", seg_ticks[0], P_RLOW);
            chk(seg_pins[1] == 4'b1100, "R2 cold phase2 pins", int'(seg_pins[1]), 12);
            chk(seg_ticks[1] == P_RREC, "R2 R10 cold recovery ticks", seg_ticks[1], P_RREC);
            final_seg = 2;
        end
        chk(seg_pins[final_seg] == 4'b1101, "R4 run pins", int'(seg_pins[final_seg]), 13);
        chk(seg == final_seg, "R4 R9 phase count", seg, final_seg);

        j = exp_sample(raise_at, pulse_at);
        ok_exp = (j <= P_TRIES - 1);
        if (ok_exp) begin
            chk(done_cnt == 1, "R6 done pulse once", done_cnt, 1);
            chk(!timeout_err, "R6 no error on success", int'(timeout_err), 0);
            chk(pd == j * P_GAP, "R5 success sample tick", pd, j * P_GAP);
        end else begin
            chk(done_cnt == 0, "R7 no done on timeout", done_cnt, 0);
            chk(timeout_err, "R7 error set", int'(timeout_err), 1);
            chk(pd == (P_TRIES - 1) * P_GAP, "R7 timeout tick", pd, (P_TRIES - 1) * P_GAP);
        end

        repeat (6) @(posedge clk);
        #2;
        chk(pins == 4'b1101 && seg == final_seg, "R4 run pins held", int'(pins), 13);
        chk(timeout_err == !ok_exp, "R8 error sticky", int'(timeout_err), int'(!ok_exp));
        chk(!busy, "R6 R7 idle after end", int'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails = fails + 1;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #2;
        chk(pins == 4'b0000, "R1 pins in reset", int'(pins), 0);
        chk({busy, done, timeout_err} == 3'b000, "R1 status in reset",
            int'({busy, done, timeout_err}), 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        chk(pins == 4'b0000 && !busy, "R1 idle after reset", int'(pins), 0);

        for (int d = 2; d <= 4; d++) begin
            tick_div = d;
            // sweep the point where ready rises, across all sample slots and beyond
            for (int t = 0; t <= P_GAP * P_TRIES + 1; t++) begin
                run_case(1'b0, t, -1, 0);
            end
            run_case(1'b0, -1, -1, 0);
            run_case(1'b1, 0, -1, 0);
            run_case(1'b1, 7, -1, 0);
            run_case(1'b1, -1, -1, 0);
            // R5: a ready pulse between samples is ignored, one on a sample is taken
            run_case(1'b0, -1, P_GAP + 1, 0);
            run_case(1'b0, -1, 2 * P_GAP, 0);
            run_case(1'b1, -1, 3 * P_GAP - 1, 0);
            // R9: start during reset phases and during the run phase
            run_case(1'b0, 10, -1, 3);
            run_case(1'b1, 10, -1, 4);
            run_case(1'b0, 14, -1, 40);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule